// File: doc/BRIEF.md
# Camera Frame-Buffer SPI Register Port

This block is the slave end of a byte-wide SPI link that lets a host processor reach a camera frame buffer. Each byte on the link has its own chip-select frame. A command byte says whether the host reads or writes and names a register. A write is completed by a second, separately framed value byte. A small register set holds a 24-bit buffer pointer, a pause control, a status code and a data window into the buffer. The data window can step the pointer forward after every read, so the host can stream a line of pixels.

Replies are pipelined. The byte shifted out during a frame is the answer to the latest read command that came before it, so the host discards the first reply after it issues a new read. On the other side, the capture logic writes 16-bit RGB565 pixels by line and column. A pause request freezes these writes after a fixed number of clock cycles, so the host reads a stable picture. The status register reports when the freeze has taken effect.

Top module: `fbp_port`

## Requirements
- R1: A command byte is decoded as follows: bit 7 = 1 is a read and bit 7 = 0 is a write; bit 5 = 1 asks for pointer auto-increment; bits 3:0 select the register. Bits 6 and 4 are ignored.
- R2: A write command is not acted on until the next complete frame. That frame's byte is taken as the value and is never decoded as a command.
- R3: The byte shifted out during a frame is the result of the most recent read command completed before that frame started. Write commands and value bytes leave it unchanged. After reset it is 0x00.
- R4: Registers 0, 1 and 2 hold pointer bits 7:0, 15:8 and 23:16. Each is written by value and reads back.
- R5: Register 3 is the control register. Bit 0 = 1 requests a pause and bit 0 = 0 resumes. A read returns 0x01 or 0x00.
- R6: Register 4 is the status register. It reads 0x51 once the pause is in effect and 0x50 otherwise. The pause takes effect PAUSE_CYCLES clock cycles after the value byte is taken, and output cap_hold shows it. Resume clears it on the next cycle.
- R7: Register 8 returns the buffer byte at the pointer. With the increment flag set, the pointer then advances by one and wraps from 0xFFFFFF to 0. Without the flag, the pointer does not move.
- R8: A capture write of pixel (line, x) puts the low byte at line*2*LINE_PIXELS + 2*x and the high byte at the next address. Capture writes are ignored while cap_hold is 1.
- R9: Registers 5, 6, 7 and 9 to 15 read 0x00 and ignore writes.
- R10: The link uses SPI mode 0, MSB first, 8 bits per frame. The bit counter clears whenever chip select is high, so a partial frame is discarded.
- R11: After reset the pointer and control are 0, status reads 0x50, cap_hold is 0, and spi_miso is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low, one frame per byte |
| spi_mosi | input | 1 | Host-to-port serial data |
| spi_miso | output | 1 | Port-to-host serial data, 0 when not selected |
| cam_we | input | 1 | Capture pixel write strobe |
| cam_line | input | $clog2(LINES) | Line number of the captured pixel |
| cam_x | input | $clog2(LINE_PIXELS) | Column of the captured pixel |
| cam_pixel | input | 16 | RGB565 pixel value |
| cap_hold | output | 1 | High while the buffer is frozen for host reading |

## Verification
Every SPI input passes through a two-stage synchronizer and one edge register, so a received byte acts about three clock cycles after its eighth rising sck edge. Its reply is loaded about three cycles after the next chip-select fall. The bench keeps at least six clock cycles between each SPI edge and the point where it samples miso, and it reads replies only one frame later. cap_hold is sampled well past PAUSE_CYCLES after the pause value byte, and a few cycles after the resume byte. Buffer effects of capture writes are observed through a later SPI data read, never by looking inside the memory.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 24;

  typedef enum logic [3:0] {
    REG_ADDR0 = 4'd0,
    REG_ADDR1 = 4'd1,
    REG_ADDR2 = 4'd2,
    REG_CTRL  = 4'd3,
    REG_STAT  = 4'd4,
    REG_DATA  = 4'd8
  } fbp_reg_e;

  localparam logic [BYTE_W-1:0] STAT_RUN  = 8'h50;
  localparam logic [BYTE_W-1:0] STAT_HELD = 8'h51;

  typedef struct packed {
    logic       rd;
    logic       inc;
    logic [3:0] sel;
  } fbp_cmd_t;

  // split a command byte into its fields
  function automatic fbp_cmd_t fbp_decode(input logic [BYTE_W-1:0] b);
    fbp_cmd_t c;
    c.rd  = b[7];
    c.inc = b[5];
    c.sel = b[3:0];
    return c;
  endfunction

  // byte address of the low half of a pixel
  function automatic logic [PTR_W-1:0] fbp_pix_addr(input logic [PTR_W-1:0] line,
                                                    input logic [PTR_W-1:0] x,
                                                    input logic [PTR_W-1:0] line_bytes);
    return line * line_bytes + (x << 1);
  endfunction

  function automatic logic [BYTE_W-1:0] fbp_status(input logic held);
    return held ? STAT_HELD : STAT_RUN;
  endfunction

endpackage

// File: rtl/fbp_shifter.sv
module fbp_shifter
  import fbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0] sck_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  // named events for checks
  logic sck_rise, sck_fall, cs_act, cs_fall;

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign cs_act   = ~cs_q[1];
  assign cs_fall  = ~cs_q[1] & cs_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_sh <= {rx_sh[BYTE_W-2:0], mosi_q[1]};
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          bit_cnt  <= '0;
          rx_valid <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (cs_fall) begin
        tx_sh <= tx_byte;
      end else if (cs_act && sck_fall) begin
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign rx_byte  = rx_sh;
  assign spi_miso = cs_act & tx_sh[BYTE_W-1];

  // R10: a byte only completes inside a selected frame
  a_r10_framed_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(cs_act));

endmodule

// File: rtl/fbp_regs.sv
module fbp_regs
  import fbp_pkg::*;
#(
  parameter int PAUSE_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic [BYTE_W-1:0] resp,
  output logic [PTR_W-1:0]  buf_addr,
  output logic              hold
);

  localparam int PCW = $clog2(PAUSE_CYCLES + 1);

  fbp_cmd_t          cmd;
  logic              val_phase;
  logic [3:0]        pend_sel;
  logic              ctrl_pause;
  logic [PCW-1:0]    pcnt;
  logic [BYTE_W-1:0] rd_val;

  // named events
  logic cmd_evt, val_evt, rd_evt, wr_cmd_evt, data_inc_evt;

  assign cmd          = fbp_decode(rx_byte);
  assign cmd_evt      = rx_valid & ~val_phase;
  assign val_evt      = rx_valid & val_phase;
  assign rd_evt       = cmd_evt & cmd.rd;
  assign wr_cmd_evt   = cmd_evt & ~cmd.rd;
  assign data_inc_evt = rd_evt & cmd.inc & (cmd.sel == REG_DATA);

  always_comb begin
    case (cmd.sel)
      REG_ADDR0: rd_val = buf_addr[7:0];
      REG_ADDR1: rd_val = buf_addr[15:8];
      REG_ADDR2: rd_val = buf_addr[23:16];
      REG_CTRL:  rd_val = {7'd0, ctrl_pause};
      REG_STAT:  rd_val = fbp_status(hold);
      REG_DATA:  rd_val = ram_rdata;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_phase  <= 1'b0;
      pend_sel   <= '0;
      resp       <= '0;
      buf_addr   <= '0;
      ctrl_pause <= 1'b0;
    end else begin
      if (wr_cmd_evt) begin
        val_phase <= 1'b1;
        pend_sel  <= cmd.sel;
      end else if (val_evt) begin
        val_phase <= 1'b0;
      end
      if (rd_evt) resp <= rd_val;
      if (val_evt) begin
        case (pend_sel)
          REG_ADDR0: buf_addr[7:0]   <= rx_byte;
          REG_ADDR1: buf_addr[15:8]  <= rx_byte;
          REG_ADDR2: buf_addr[23:16] <= rx_byte;
          REG_CTRL:  ctrl_pause      <= rx_byte[0];
          default:   ;
        endcase
      end else if (data_inc_evt) begin
        buf_addr <= buf_addr + 24'd1;
      end
    end
  end

  // pause takes effect after PAUSE_CYCLES, resume is immediate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      hold <= 1'b0;
    end else if (!ctrl_pause) begin
      pcnt <= '0;
      hold <= 1'b0;
    end else if (!hold) begin
      if (pcnt == PCW'(PAUSE_CYCLES - 1)) hold <= 1'b1;
      else pcnt <= pcnt + 1'b1;
    end
  end

  // R7: an incrementing data read steps the pointer by one (wrapping)
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    data_inc_evt |=> buf_addr == $past(buf_addr) + 24'd1);

  // R3: the reply only changes on a read command
  a_r3_resp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(resp));

  // R6: freeze only rises on an earlier, still present request
  a_r6_hold_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> ctrl_pause && $past(ctrl_pause));

  // R6: resume releases the freeze next cycle
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_pause |=> !hold);

endmodule

// File: rtl/fbp_ram.sv
module fbp_ram
  import fbp_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [15:0]       wr_data,
  input  logic [IDX_W:0]    rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  logic odd_q;

  // even byte lane and odd byte lane
  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [WORDS];
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data[BYTE_W*b +: BYTE_W];
      q <= mem[rd_addr[IDX_W:1]];
    end
  end

  always_ff @(posedge clk) odd_q <= rd_addr[0];

  assign rd_data = odd_q ? g_lane[1].q : g_lane[0].q;

endmodule

// File: rtl/fbp_port.sv
module fbp_port
  import fbp_pkg::*;
#(
  parameter int LINE_PIXELS  = 8,
  parameter int LINES        = 8,
  parameter int PAUSE_CYCLES = 256,
  localparam int X_W        = $clog2(LINE_PIXELS),
  localparam int LINE_W     = $clog2(LINES),
  localparam int WORDS      = LINE_PIXELS * LINES,
  localparam int IDX_W      = $clog2(WORDS),
  localparam int LINE_BYTES = 2 * LINE_PIXELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              cam_we,
  input  logic [LINE_W-1:0] cam_line,
  input  logic [X_W-1:0]    cam_x,
  input  logic [15:0]       cam_pixel,
  output logic              cap_hold
);

  logic [BYTE_W-1:0] rx_byte, resp, ram_rdata;
  logic              rx_valid;
  logic [PTR_W-1:0]  buf_addr;
  logic              ram_we;
  logic [IDX_W-1:0]  pix_idx;

  assign ram_we  = cam_we & ~cap_hold;
  assign pix_idx = IDX_W'(fbp_pix_addr(PTR_W'(cam_line), PTR_W'(cam_x),
                                       PTR_W'(LINE_BYTES)) >> 1);

  fbp_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso),
    .tx_byte  (resp),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid)
  );

  fbp_regs #(.PAUSE_CYCLES(PAUSE_CYCLES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .ram_rdata (ram_rdata),
    .resp      (resp),
    .buf_addr  (buf_addr),
    .hold      (cap_hold)
  );

  fbp_ram #(.WORDS(WORDS)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_idx  (pix_idx),
    .wr_data (cam_pixel),
    .rd_addr (buf_addr[IDX_W:0]),
    .rd_data (ram_rdata)
  );

endmodule

// File: tb/sim_fbp_port.sv
`timescale 1ns/1ps
module sim_fbp_port;

  localparam int LP = 8;
  localparam int LN = 8;
  localparam int PC = 256;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic cam_we = 1'b0;
  logic [2:0] cam_line = '0;
  logic [2:0] cam_x = '0;
  logic [15:0] cam_pixel = '0;
  logic cap_hold;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fbp_port #(.LINE_PIXELS(LP), .LINES(LN), .PAUSE_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cam_we(cam_we),
    .cam_line(cam_line), .cam_x(cam_x), .cam_pixel(cam_pixel),
    .cap_hold(cap_hold));

  // pixel pattern: low = line*8+x, high = 0xA0+line
  function automatic logic [15:0] pat(input int l, input int x);
    return {8'(8'hA0 + l), 8'(l * LP + x)};
  endfunction

  // {sent byte, expected reply}; pointer set to line 1, x 2 = byte 20
  localparam logic [15:0] VEC [22] = '{
    16'h8400, 16'h8050, 16'h0000, 16'h1400, 16'h8000, 16'hA814,
    16'hA80A, 16'h88A1, 16'h880B, 16'h800B, 16'h8F16, 16'h0700,
    16'h5A00, 16'h8100, 16'h8200, 16'h8300, 16'h8400, 16'hE850,
    16'h800B, 16'h8017, 16'h9017, 16'h8417};

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] r, input logic [7:0] v);
    logic [7:0] d;
    xfer({4'h0, r}, d);
    xfer(v, d);
  endtask

  task automatic cam(input int l, input int x, input logic [15:0] p);
    @(negedge clk);
    cam_we = 1'b1; cam_line = 3'(l); cam_x = 3'(x); cam_pixel = p;
    @(negedge clk);
    cam_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({7'd0, cap_hold}, 8'h00, "R11 cap_hold after reset");
    chk({7'd0, spi_miso}, 8'h00, "R11 miso idle");

    for (int l = 0; l < LN; l++)
      for (int x = 0; x < LP; x++) cam(l, x, pat(l, x));

    // vector walk: R1 R2 R3 R4 R7 R8 R9 R11
    for (int i = 0; i < 22; i++) begin
      xfer(VEC[i][15:8], rx);
      chk(rx, VEC[i][7:0], $sformatf("R1 R3 R7 R9 vector %0d", i));
    end

    // R7 wrap of the 24-bit pointer, R4 readback of all bytes
    wr(4'd0, 8'hFF); wr(4'd1, 8'hFF); wr(4'd2, 8'hFF);
    xfer(8'hA8, rx);
    xfer(8'h80, rx); chk(rx, pat(7, 7) >> 8, "R7 byte at top address");
    xfer(8'h81, rx); chk(rx, 8'h00, "R7 wrap addr0");
    xfer(8'h82, rx); chk(rx, 8'h00, "R4 wrap addr1");
    xfer(8'h84, rx); chk(rx, 8'h00, "R4 wrap addr2");

    // R6 pause handshake
    wr(4'd3, 8'h01);
    chk({7'd0, cap_hold}, 8'h00, "R6 hold not yet");
    xfer(8'h84, rx);
    xfer(8'h83, rx); chk(rx, 8'h50, "R6 status before latency");
    repeat (PC + 20) @(negedge clk);
    chk({7'd0, cap_hold}, 8'h01, "R6 hold after latency");
    xfer(8'h84, rx); chk(rx, 8'h01, "R5 control readback");
    xfer(8'h84, rx); chk(rx, 8'h51, "R6 status held");

    // R8 capture write ignored while held
    cam(1, 2, 16'hFFFF);
    wr(4'd0, 8'h14); wr(4'd1, 8'h00); wr(4'd2, 8'h00);
    xfer(8'h88, rx);
    xfer(8'h84, rx); chk(rx, 8'h0A, "R8 write blocked while held");

    // R5 resume
    wr(4'd3, 8'h00);
    repeat (4) @(negedge clk);
    chk({7'd0, cap_hold}, 8'h00, "R5 resume releases hold");
    xfer(8'h84, rx);
    cam(1, 2, 16'h5AC3);
    xfer(8'hA8, rx); chk(rx, 8'h50, "R6 status after resume");
    xfer(8'hA8, rx); chk(rx, 8'hC3, "R8 low byte at even address");
    xfer(8'h84, rx); chk(rx, 8'h5A, "R8 high byte next address");

    // R10 partial frame is discarded
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      spi_mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(8'h84, rx);
    xfer(8'h80, rx); chk(rx, 8'h50, "R10 realign after partial frame");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule